// File: doc/BRIEF.md
# Display Identification Block Checksum Reader

This block fetches the identification data of an attached display and decides whether it can be trusted. It does not drive the serial bus itself. It issues read and write requests to a separate bus master over a small request channel, and it takes the returned bytes one at a time from a valid/ready response stream. The identification data lives in two address spaces: the identification device, at 7-bit device address 0x50, and the sink's own configuration space.

A run starts when `start_i` is seen in idle. The block first reads the extension-count byte, which sits at offset 126 of the base block. It then reads the base block and, when the count is nonzero, one extension block, 128 bytes each. Every block has to sum to zero modulo 256. Any bus error or bad sum ends the run at once with a failure. When the blocks pass, the block reads the sink's test-request byte. If the identification-read test bit is set, it writes back the checksum byte, then a response code. The run ends with a one-cycle `done_o` pulse. `fail_o` holds the outcome and `csum_o` holds the checksum byte of the last block that was read.

Top module: `dispid_csum_reader`

## Requirements
- R1: After reset, `req_valid_o`, `rsp_ready_o`, `done_o` and `fail_o` are 0, and `csum_o` is 0x00.
- R2: `start_i` in idle makes the first request a read (`req_write_o`=0) in space 0 (`req_space_o`=0) from device 0x50, offset 126, length 1. A `start_i` seen while a run is in progress has no effect on the request sequence.
- R3: An extension byte of 0 leads to one block read at offset 0 with length 128. A nonzero byte leads to a second read, at offset 128 with length 128, after the first block passes. Any value above 1 behaves as 1, so at most two blocks are read.
- R4: A block passes only when the 8-bit wrapping sum of all 128 of its bytes is zero. The sum restarts for each block.
- R5: A block that fails its sum ends the run with `fail_o`=1, and no further request is made. In particular, the second block is not read when the first one fails.
- R6: A response beat with `rsp_err_i`=1 ends the run with `fail_o`=1, and no further request is made.
- R7: After all blocks pass, the block reads one byte in space 1 at address 0x218. If bit 2 of that byte is set, it writes the checksum byte to space-1 address 0x261, then writes 0x04 to space-1 address 0x260. Each write waits for its single acknowledge beat. If bit 2 is clear, no write is made, whatever the other bits hold. Writes only ever target space 1.
- R8: `csum_o` equals byte 127 of the last block that was read, whether that block passed or failed.
- R9: `done_o` is high for exactly one cycle per run. `fail_o` is valid with it and holds its value until the next accepted start, which clears it.
- R10: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and all request fields stay unchanged.
- R11: `rsp_ready_o` is high only while a response is awaited, and is low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (taken in idle only) |
| req_valid_o | output | 1 | Request presented to the bus master |
| req_ready_i | input | 1 | Bus master accepts the request |
| req_write_o | output | 1 | 1 = write one byte, 0 = read |
| req_space_o | output | 1 | 0 = identification device, 1 = sink configuration space |
| req_dev_o | output | 7 | Device address for space 0 |
| req_addr_o | output | 20 | Byte offset or register address |
| req_len_o | output | 8 | Number of bytes to read |
| req_wdata_o | output | 8 | Byte to write |
| rsp_valid_i | input | 1 | Response beat valid (one per read byte, one acknowledge per write) |
| rsp_ready_o | output | 1 | Block accepts the response beat |
| rsp_data_i | input | 8 | Read byte |
| rsp_err_i | input | 1 | Bus error flagged on this beat |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Outcome of the last run, 1 = failure |
| csum_o | output | 8 | Checksum byte of the last block read |

## Verification
The bench drives a responder that stalls every request for one cycle, and it targets the choices that depend on the extension byte. With a count of zero, a design that ignores the count would read a second block. With a count of five, a design that does not cap the count would read too many blocks or pick the wrong offset. A bad base block shows whether the extension block is still fetched by mistake. A bad extension block shows whether the reported checksum follows the last block read or the last block that passed. A test byte with every bit set except bit 2 catches decoding of the wrong bit. A bus error in the middle of a block catches a design that waits for the rest of the block. A second start inside a run catches a sequence that restarts. The stall itself catches request fields that change before they are accepted.

// File: rtl/dispid_pkg.sv
package dispid_pkg;

   // Sequencer states: each request state is followed by its response state.
   typedef enum logic [3:0] {
      S_IDLE    = 4'd0,
      S_EXT_REQ = 4'd1,
      S_EXT_RSP = 4'd2,
      S_BLK_REQ = 4'd3,
      S_BLK_RSP = 4'd4,
      S_TST_REQ = 4'd5,
      S_TST_RSP = 4'd6,
      S_WCS_REQ = 4'd7,
      S_WCS_RSP = 4'd8,
      S_WRC_REQ = 4'd9,
      S_WRC_RSP = 4'd10
   } seq_st_e;

   localparam logic SPACE_IDDEV = 1'b0;
   localparam logic SPACE_SINK  = 1'b1;

endpackage

// File: rtl/dispid_beat_cnt.sv
module dispid_beat_cnt #(
   parameter int unsigned BLK_BYTES = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int unsigned CW = $clog2(BLK_BYTES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (inc_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == CW'(BLK_BYTES - 1));

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0) && !last_o); // R4

endmodule

// File: rtl/dispid_sum_acc.sv
module dispid_sum_acc #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          en_i,
   input  logic [DW-1:0] byte_i,
   output logic [DW-1:0] sum_nxt_o
);
   logic [DW-1:0] sum_q;

   // Wrapping add: the carry out of DW bits is dropped on purpose.
   assign sum_nxt_o = sum_q + byte_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sum_q <= '0;
      else if (clr_i)
         sum_q <= '0;
      else if (en_i)
         sum_q <= sum_nxt_o;
   end

   AST_SUM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (sum_q == '0)); // R4

endmodule

// File: rtl/dispid_seq.sv
module dispid_seq
   import dispid_pkg::*;
#(
   parameter int unsigned ADDR_W        = 20,
   parameter int unsigned BLK_BYTES     = 128,
   parameter int unsigned MAX_BLKS      = 2,
   parameter logic [6:0]  DEV_ADDR      = 7'h50,
   parameter int unsigned TST_REQ_ADDR  = 32'h218,
   parameter int unsigned TST_CSUM_ADDR = 32'h261,
   parameter int unsigned TST_RESP_ADDR = 32'h260,
   parameter int unsigned TST_BIT       = 2,
   parameter logic [7:0]  RESP_CODE     = 8'h04
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   output logic                         req_valid_o,
   input  logic                         req_ready_i,
   output logic                         req_write_o,
   output logic                         req_space_o,
   output logic [6:0]                   req_dev_o,
   output logic [ADDR_W-1:0]            req_addr_o,
   output logic [$clog2(BLK_BYTES+1)-1:0] req_len_o,
   output logic [7:0]                   req_wdata_o,
   input  logic                         rsp_valid_i,
   output logic                         rsp_ready_o,
   input  logic [7:0]                   rsp_data_i,
   input  logic                         rsp_err_i,
   input  logic                         blk_last_i,
   input  logic [7:0]                   sum_nxt_i,
   output logic                         sum_clr_o,
   output logic                         beat_en_o,
   output logic                         done_o,
   output logic                         fail_o,
   output logic [7:0]                   csum_o
);
   localparam int unsigned LEN_W   = $clog2(BLK_BYTES + 1);
   localparam int unsigned BLK_SH  = $clog2(BLK_BYTES);
   localparam int unsigned BLK_W   = $clog2(MAX_BLKS + 1);
   localparam int unsigned EXT_OFS = BLK_BYTES - 2;

   seq_st_e          st_q;
   logic [BLK_W-1:0] blk_idx_q;
   logic [BLK_W-1:0] blk_tot_q;
   logic [BLK_W-1:0] blk_tot_w;
   logic [7:0]       csum_q;
   logic             done_q;
   logic             fail_q;
   logic             beat_fire;
   logic             more_blks;

   // Number of blocks implied by the extension byte on the response bus.
   generate
      if (MAX_BLKS == 1) begin : g_single
         assign blk_tot_w = BLK_W'(1);
      end else begin : g_multi
         always_comb begin
            if (rsp_data_i >= 8'(MAX_BLKS - 1))
               blk_tot_w = BLK_W'(MAX_BLKS);
            else
               blk_tot_w = BLK_W'(rsp_data_i) + 1'b1;
         end
      end
   endgenerate

   assign rsp_ready_o = (st_q == S_EXT_RSP) || (st_q == S_BLK_RSP) ||
                        (st_q == S_TST_RSP) || (st_q == S_WCS_RSP) ||
                        (st_q == S_WRC_RSP);
   assign beat_fire   = rsp_valid_i && rsp_ready_o;
   assign sum_clr_o   = (st_q == S_BLK_REQ) && req_ready_i;
   assign beat_en_o   = beat_fire && (st_q == S_BLK_RSP);
   assign more_blks   = (blk_idx_q + 1'b1) < blk_tot_q;

   // Request fields: decoded from state and held registers only.
   always_comb begin
      req_valid_o = 1'b0;
      req_write_o = 1'b0;
      req_space_o = SPACE_IDDEV;
      req_dev_o   = DEV_ADDR;
      req_addr_o  = '0;
      req_len_o   = LEN_W'(1);
      req_wdata_o = 8'h00;
      unique case (st_q)
         S_EXT_REQ: begin
            req_valid_o = 1'b1;
            req_addr_o  = ADDR_W'(EXT_OFS);
         end
         S_BLK_REQ: begin
            req_valid_o = 1'b1;
            req_addr_o  = ADDR_W'(blk_idx_q) << BLK_SH;
            req_len_o   = LEN_W'(BLK_BYTES);
         end
         S_TST_REQ: begin
            req_valid_o = 1'b1;
            req_space_o = SPACE_SINK;
            req_addr_o  = ADDR_W'(TST_REQ_ADDR);
         end
         S_WCS_REQ: begin
            req_valid_o = 1'b1;
            req_write_o = 1'b1;
            req_space_o = SPACE_SINK;
            req_addr_o  = ADDR_W'(TST_CSUM_ADDR);
            req_wdata_o = csum_q;
         end
         S_WRC_REQ: begin
            req_valid_o = 1'b1;
            req_write_o = 1'b1;
            req_space_o = SPACE_SINK;
            req_addr_o  = ADDR_W'(TST_RESP_ADDR);
            req_wdata_o = RESP_CODE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         blk_idx_q <= '0;
         blk_tot_q <= BLK_W'(1);
         csum_q    <= 8'h00;
         done_q    <= 1'b0;
         fail_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            S_IDLE: begin
               if (start_i) begin
                  fail_q    <= 1'b0;
                  blk_idx_q <= '0;
                  st_q      <= S_EXT_REQ;
               end
            end
            S_EXT_REQ: if (req_ready_i) st_q <= S_EXT_RSP;
            S_EXT_RSP: begin
               if (beat_fire) begin
                  if (rsp_err_i) begin
                     done_q <= 1'b1;
                     fail_q <= 1'b1;
                     st_q   <= S_IDLE;
                  end else begin
                     blk_tot_q <= blk_tot_w;
                     st_q      <= S_BLK_REQ;
                  end
               end
            end
            S_BLK_REQ: if (req_ready_i) st_q <= S_BLK_RSP;
            S_BLK_RSP: begin
               if (beat_fire) begin
                  if (rsp_err_i) begin
                     done_q <= 1'b1;
                     fail_q <= 1'b1;
                     st_q   <= S_IDLE;
                  end else if (blk_last_i) begin
                     csum_q <= rsp_data_i;
                     if (sum_nxt_i != 8'h00) begin
                        done_q <= 1'b1;
                        fail_q <= 1'b1;
                        st_q   <= S_IDLE;
                     end else if (more_blks) begin
                        blk_idx_q <= blk_idx_q + 1'b1;
                        st_q      <= S_BLK_REQ;
                     end else begin
                        st_q <= S_TST_REQ;
                     end
                  end
               end
            end
            S_TST_REQ: if (req_ready_i) st_q <= S_TST_RSP;
            S_TST_RSP: begin
               if (beat_fire) begin
                  if (rsp_err_i) begin
                     done_q <= 1'b1;
                     fail_q <= 1'b1;
                     st_q   <= S_IDLE;
                  end else if (rsp_data_i[TST_BIT]) begin
                     st_q <= S_WCS_REQ;
                  end else begin
                     done_q <= 1'b1;
                     st_q   <= S_IDLE;
                  end
               end
            end
            S_WCS_REQ: if (req_ready_i) st_q <= S_WCS_RSP;
            S_WCS_RSP: begin
               if (beat_fire) begin
                  if (rsp_err_i) begin
                     done_q <= 1'b1;
                     fail_q <= 1'b1;
                     st_q   <= S_IDLE;
                  end else begin
                     st_q <= S_WRC_REQ;
                  end
               end
            end
            S_WRC_REQ: if (req_ready_i) st_q <= S_WRC_RSP;
            S_WRC_RSP: begin
               if (beat_fire) begin
                  done_q <= 1'b1;
                  fail_q <= rsp_err_i;
                  st_q   <= S_IDLE;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign done_o = done_q;
   assign fail_o = fail_q;
   assign csum_o = csum_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> req_valid_o && $stable(req_addr_o) && $stable(req_write_o) && $stable(req_space_o) && $stable(req_len_o) && $stable(req_wdata_o)); // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_FAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && !start_i) |=> fail_o); // R9
   AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_fire && rsp_err_i) |=> done_o && fail_o && !req_valid_o); // R6
   AST_BAD_SUM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_en_o && blk_last_i && (sum_nxt_i != 8'h00)) |=> done_o && fail_o && !req_valid_o); // R5
   AST_WRITE_TO_SINK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && req_write_o) |-> (req_space_o == SPACE_SINK)); // R7
   AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE) |-> !rsp_ready_o && !req_valid_o); // R11

endmodule

// File: rtl/dispid_csum_reader.sv
module dispid_csum_reader #(
   parameter int unsigned ADDR_W        = 20,
   parameter int unsigned BLK_BYTES     = 128,
   parameter int unsigned MAX_BLKS      = 2,
   parameter logic [6:0]  DEV_ADDR      = 7'h50,
   parameter int unsigned TST_REQ_ADDR  = 32'h218,
   parameter int unsigned TST_CSUM_ADDR = 32'h261,
   parameter int unsigned TST_RESP_ADDR = 32'h260,
   parameter int unsigned TST_BIT       = 2,
   parameter logic [7:0]  RESP_CODE     = 8'h04,
   localparam int unsigned LEN_W        = $clog2(BLK_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic              req_write_o,
   output logic              req_space_o,
   output logic [6:0]        req_dev_o,
   output logic [ADDR_W-1:0] req_addr_o,
   output logic [LEN_W-1:0]  req_len_o,
   output logic [7:0]        req_wdata_o,
   input  logic              rsp_valid_i,
   output logic              rsp_ready_o,
   input  logic [7:0]        rsp_data_i,
   input  logic              rsp_err_i,
   output logic              done_o,
   output logic              fail_o,
   output logic [7:0]        csum_o
);
   // Elaboration-time parameter checks.
   generate
      if (BLK_BYTES < 4 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two of at least 4");
      end
      if (MAX_BLKS < 1 || MAX_BLKS > 255) begin : g_bad_max
         $error("MAX_BLKS must lie in 1..255");
      end
      if (TST_BIT > 7) begin : g_bad_bit
         $error("TST_BIT must select a bit of a byte");
      end
      if (ADDR_W < $clog2(BLK_BYTES * MAX_BLKS) || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W cannot reach every block offset");
      end
   endgenerate

   logic       blk_last;
   logic [7:0] sum_nxt;
   logic       sum_clr;
   logic       beat_en;

   dispid_seq #(
      .ADDR_W        (ADDR_W),
      .BLK_BYTES     (BLK_BYTES),
      .MAX_BLKS      (MAX_BLKS),
      .DEV_ADDR      (DEV_ADDR),
      .TST_REQ_ADDR  (TST_REQ_ADDR),
      .TST_CSUM_ADDR (TST_CSUM_ADDR),
      .TST_RESP_ADDR (TST_RESP_ADDR),
      .TST_BIT       (TST_BIT),
      .RESP_CODE     (RESP_CODE)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .req_valid_o (req_valid_o),
      .req_ready_i (req_ready_i),
      .req_write_o (req_write_o),
      .req_space_o (req_space_o),
      .req_dev_o   (req_dev_o),
      .req_addr_o  (req_addr_o),
      .req_len_o   (req_len_o),
      .req_wdata_o (req_wdata_o),
      .rsp_valid_i (rsp_valid_i),
      .rsp_ready_o (rsp_ready_o),
      .rsp_data_i  (rsp_data_i),
      .rsp_err_i   (rsp_err_i),
      .blk_last_i  (blk_last),
      .sum_nxt_i   (sum_nxt),
      .sum_clr_o   (sum_clr),
      .beat_en_o   (beat_en),
      .done_o      (done_o),
      .fail_o      (fail_o),
      .csum_o      (csum_o)
   );

   dispid_beat_cnt #(
      .BLK_BYTES (BLK_BYTES)
   ) i_beat_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (sum_clr),
      .inc_i  (beat_en),
      .last_o (blk_last)
   );

   dispid_sum_acc #(
      .DW (8)
   ) i_sum_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (sum_clr),
      .en_i      (beat_en),
      .byte_i    (rsp_data_i),
      .sum_nxt_o (sum_nxt)
   );

endmodule

// File: tb/test_dispid_csum_reader.sv
`timescale 1ns/1ps
module test_dispid_csum_reader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        req_valid_o;
   logic        req_ready_i = 1'b0;
   logic        req_write_o;
   logic        req_space_o;
   logic [6:0]  req_dev_o;
   logic [19:0] req_addr_o;
   logic [7:0]  req_len_o;
   logic [7:0]  req_wdata_o;
   logic        rsp_valid_i = 1'b0;
   logic        rsp_ready_o;
   logic [7:0]  rsp_data_i = 8'h00;
   logic        rsp_err_i = 1'b0;
   logic        done_o;
   logic        fail_o;
   logic [7:0]  csum_o;

   always #2 clk = ~clk; // 250 MHz

   dispid_csum_reader i_dispid_csum_reader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
      .req_write_o(req_write_o), .req_space_o(req_space_o),
      .req_dev_o(req_dev_o), .req_addr_o(req_addr_o), .req_len_o(req_len_o),
      .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i),
      .rsp_ready_o(rsp_ready_o), .rsp_data_i(rsp_data_i), .rsp_err_i(rsp_err_i),
      .done_o(done_o), .fail_o(fail_o), .csum_o(csum_o));

   int checks = 0;
   int errors = 0;

   // Responder model state
   logic [7:0] mem [256];
   logic [7:0] test_byte = 8'h00;
   int         err_req = -1;
   int         err_beat = -1;
   int         nreq = 0;
   int         hold_bad = 0;
   logic       lg_wr [16];
   logic       lg_sp [16];
   logic [6:0] lg_dev [16];
   logic [19:0] lg_addr [16];
   logic [7:0] lg_len [16];
   logic [7:0] lg_wd [16];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Blocks: byte 126 of block 0 carries the extension count, byte 127 fixes the sum.
   task automatic build_mem(input logic [7:0] ext, input int bad_blk, input int seed);
      for (int b = 0; b < 2; b++) begin
         logic [7:0] s;
         s = 8'h00;
         for (int i = 0; i < 127; i++) begin
            mem[b*128+i] = 8'((i * 7 + b * 13 + seed) ^ (i << 3));
            if (b == 0 && i == 126) mem[i] = ext;
            s = s + mem[b*128+i];
         end
         mem[b*128+127] = 8'h00 - s;
         if (b == bad_blk) mem[b*128+5] = mem[b*128+5] + 8'h01;
      end
   endtask

   // Responder: stalls each request one cycle, then serves its beats.
   initial begin : responder
      forever begin
         @(negedge clk);
         if (req_valid_o) begin
            logic [44:0] snap;
            int idx;
            int nb;
            snap = {req_write_o, req_space_o, req_dev_o, req_addr_o, req_len_o, req_wdata_o};
            @(negedge clk);
            if (!req_valid_o ||
                snap != {req_write_o, req_space_o, req_dev_o, req_addr_o, req_len_o, req_wdata_o})
               hold_bad++;
            idx = nreq;
            if (idx < 16) begin
               lg_wr[idx] = req_write_o; lg_sp[idx] = req_space_o; lg_dev[idx] = req_dev_o;
               lg_addr[idx] = req_addr_o; lg_len[idx] = req_len_o; lg_wd[idx] = req_wdata_o;
            end
            nb = req_write_o ? 1 : int'(req_len_o);
            req_ready_i = 1'b1;
            @(negedge clk);
            req_ready_i = 1'b0;
            nreq++;
            for (int k = 0; k < nb; k++) begin
               rsp_valid_i = 1'b1;
               rsp_err_i = (idx == err_req && k == err_beat);
               if (idx < 16 && lg_wr[idx]) rsp_data_i = 8'h00;
               else if (idx < 16 && lg_sp[idx]) rsp_data_i = test_byte;
               else rsp_data_i = mem[(int'(lg_addr[idx]) + k) % 256];
               #1;
               while (!rsp_ready_o) begin @(negedge clk); #1; end
               @(negedge clk);
               if (rsp_err_i) break;
            end
            rsp_valid_i = 1'b0;
            rsp_err_i = 1'b0;
         end
      end
   end

   task automatic kick();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output bit f, output logic [7:0] cs);
      int n;
      n = 0;
      while (!done_o && n < 5000) begin @(negedge clk); n++; end
      chk(done_o, "R9", "done seen", int'(done_o), 1);
      f = fail_o;
      cs = csum_o;
      @(negedge clk);
      chk(!done_o, "R9", "done single cycle", int'(done_o), 0);
      chk(!rsp_ready_o && !req_valid_o, "R11", "idle after done", int'(rsp_ready_o), 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic setup(input logic [7:0] ext, input int bad, input logic [7:0] tb_v,
                        input int er, input int eb, input int seed);
      build_mem(ext, bad, seed);
      test_byte = tb_v; err_req = er; err_beat = eb;
      nreq = 0; hold_bad = 0;
   endtask

   task automatic t_reset();
      chk(!req_valid_o && !rsp_ready_o, "R1", "reset handshake", int'({req_valid_o, rsp_ready_o}), 0);
      chk(!done_o && !fail_o, "R1", "reset done/fail", int'({done_o, fail_o}), 0);
      chk(csum_o == 8'h00, "R1", "reset csum", int'(csum_o), 0);
   endtask

   task automatic t_base_only();
      bit f; logic [7:0] cs;
      setup(8'h00, -1, 8'h00, -1, -1, 3);
      kick();
      wait_done(f, cs);
      chk(nreq == 3, "R3", "request count base only", nreq, 3);
      chk(!lg_wr[0] && !lg_sp[0] && lg_dev[0] == 7'h50 && lg_addr[0] == 20'd126 && lg_len[0] == 8'd1,
          "R2", "extension read fields", int'(lg_addr[0]), 126);
      chk(!lg_wr[1] && lg_addr[1] == 20'd0 && lg_len[1] == 8'd128, "R3", "base block read", int'(lg_addr[1]), 0);
      chk(!lg_wr[2] && lg_sp[2] && lg_addr[2] == 20'h218, "R7", "test request read", int'(lg_addr[2]), 'h218);
      chk(!f, "R4", "valid base block passes", int'(f), 0);
      chk(cs == mem[127], "R8", "csum base block", int'(cs), int'(mem[127]));
      chk(hold_bad == 0, "R10", "request held under stall", hold_bad, 0);
   endtask

   task automatic t_two_blocks_test();
      bit f; logic [7:0] cs;
      setup(8'h01, -1, 8'h04, -1, -1, 41);
      kick();
      wait_done(f, cs);
      chk(nreq == 6, "R7", "request count with test writes", nreq, 6);
      chk(lg_addr[2] == 20'd128 && lg_len[2] == 8'd128, "R3", "extension block read", int'(lg_addr[2]), 128);
      chk(lg_wr[4] && lg_sp[4] && lg_addr[4] == 20'h261 && lg_wd[4] == mem[255],
          "R7", "checksum write", int'(lg_wd[4]), int'(mem[255]));
      chk(lg_wr[5] && lg_sp[5] && lg_addr[5] == 20'h260 && lg_wd[5] == 8'h04,
          "R7", "response code write", int'(lg_wd[5]), 4);
      chk(!f, "R4", "two valid blocks pass", int'(f), 0);
      chk(cs == mem[255], "R8", "csum from second block", int'(cs), int'(mem[255]));
      chk(hold_bad == 0, "R10", "request held under stall", hold_bad, 0);
   endtask

   task automatic t_ext_cap();
      bit f; logic [7:0] cs;
      setup(8'h05, -1, 8'hFB, -1, -1, 99);
      kick();
      wait_done(f, cs);
      chk(nreq == 4, "R3", "extension count capped", nreq, 4);
      chk(lg_addr[2] == 20'd128, "R3", "capped second block offset", int'(lg_addr[2]), 128);
      chk(!lg_wr[3] && lg_sp[3], "R7", "no write with test bit clear", int'(lg_wr[3]), 0);
      chk(!f, "R4", "capped run passes", int'(f), 0);
   endtask

   task automatic t_bad_first();
      bit f; logic [7:0] cs;
      setup(8'h01, 0, 8'h04, -1, -1, 7);
      kick();
      wait_done(f, cs);
      chk(f, "R5", "bad base block fails", int'(f), 1);
      chk(nreq == 2, "R5", "second block not read", nreq, 2);
      chk(cs == mem[127], "R8", "csum of failed base block", int'(cs), int'(mem[127]));
   endtask

   task automatic t_bad_second();
      bit f; logic [7:0] cs;
      setup(8'h02, 1, 8'h04, -1, -1, 200);
      kick();
      wait_done(f, cs);
      chk(f, "R5", "bad extension block fails", int'(f), 1);
      chk(nreq == 3, "R5", "no test read after bad block", nreq, 3);
      chk(cs == mem[255], "R8", "csum of last block read", int'(cs), int'(mem[255]));
   endtask

   task automatic t_err_and_restart();
      bit f; logic [7:0] cs;
      // Previous run failed; an accepted start must clear the flag.
      chk(fail_o, "R9", "fail held in idle", int'(fail_o), 1);
      setup(8'h01, -1, 8'h04, 1, 40, 55);
      kick();
      chk(!fail_o, "R9", "fail cleared by start", int'(fail_o), 0);
      repeat (20) @(negedge clk);
      kick(); // second start during the run: ignored
      wait_done(f, cs);
      chk(f, "R6", "bus error fails", int'(f), 1);
      chk(nreq == 2, "R6", "no request after error", nreq, 2);
      chk(nreq == 2 && lg_addr[1] == 20'd0, "R2", "start in run ignored", nreq, 2);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_base_only();
      t_two_blocks_test();
      t_ext_cap();
      t_bad_first();
      t_bad_second();
      t_err_and_restart();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule